// File: doc/BRIEF.md
# Serial Transceiver with Switchable FIFOs

This block is a memory-mapped asynchronous serial transceiver. It sends and receives 8N1 frames: one low start bit, eight data bits least significant first, one high stop bit. The receive half and the transmit half each have their own enable, their own hold-in-reset control and their own buffer. Each buffer works either as a 16-entry FIFO or as a single holding register, and software can switch between the two at run time. Each half also has its own clock divisor. Both divisors are packed into one 32-bit register.

Software reaches the block through four 32-bit word offsets:
- data (a write sends a byte, a read takes one received byte);
- a control word on write that reads back as status;
- a fill-level word;
- the divisor register, which reads back the system clock value.

Each direction drives its own level interrupt toward an interrupt controller.

Top module: `uart_dualbuf`

## Requirements
- R1: The word offsets decode as follows.
  - 0x0 is data.
  - 0x4 is control on write and status on read.
  - 0x8 is fill status.
  - 0xC is the divisor register on write; a read of 0xC returns the SYSCLK_HZ parameter.
  - Any other address reads 0.
- R2: After reset:
  - status reads 0x0001_0001 (both buffers empty, everything else clear);
  - fill status reads 0;
  - both interrupts are low;
  - tx_line is high.
- R3: The transmitter sends each byte as one 8N1 frame, with every bit lasting exactly the transmit divisor in clock cycles. The transmit divisor is bits [31:16] of the divisor register. The line idles high.
- R4: The receiver recovers 8N1 frames with the receive divisor (bits [15:0] of the divisor register), sampling each bit near its middle. A falling edge that is no longer low half a bit later is treated as a glitch, and no byte results.
- R5: The transmit buffer and its overflow rule:
  - It holds 16 bytes when control bit 17 is set, and one byte otherwise.
  - A data write to a full buffer drops the byte and sets the sticky transmit overrun flag (status bit 20).
  - A write in the same cycle that the transmitter takes a byte from a full buffer is accepted.
- R6: The receive buffer and its read rule:
  - It holds 16 bytes when control bit 1 is set, and one byte otherwise.
  - A byte that arrives while the buffer is full is dropped and sets receive overrun (status bit 3).
  - A data read returns the oldest byte in bits [7:0] and removes it.
  - Data ready (status bit 2) clears once the buffer is empty.
  - A read of an empty buffer returns 0.
- R7: Control bit 0 enables receive and control bit 16 enables transmit. Status echoes the configuration:
  - receive FIFO enabled at bit 5, receive enabled at bit 6, receive in reset at bit 7;
  - transmit FIFO enabled at bit 22, transmit enabled at bit 23, transmit in reset at bit 24.
- R8: While control bit 2 (receive) or bit 18 (transmit) is set, that direction behaves as follows:
  - its buffer is emptied and its overrun flag is cleared;
  - its engine is stopped;
  - data writes are ignored for the transmit direction.
- R9: irq_rx is high when receive is enabled and either data is ready or receive overrun is set. irq_tx is high when transmit is enabled and either the transmit buffer is empty or transmit overrun is set. Status bit 4 mirrors irq_rx and status bit 21 mirrors irq_tx.
- R10: Fill status carries the receive buffer count in bits [7:0] and the transmit buffer count in bits [23:16].
- R11: Status bits 0 and 1 report receive empty and full, and bits 16 and 17 report transmit empty and full. Bit 18 is transmitter busy and bit 19 is transmit data loaded (buffer not empty). A byte written while transmit is disabled waits in the buffer until transmit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rx_line | input | 1 | Serial input, asynchronous |
| tx_line | output | 1 | Serial output |
| irq_rx | output | 1 | Receive interrupt, level |
| irq_tx | output | 1 | Transmit interrupt, level |

## Verification
The transmitter taking the next byte from a full single-register buffer and a software data write can land on the same clock edge. The design must accept that write without flagging overrun.

The bench provokes this case as follows:
- It queues a second byte behind a frame already being sent.
- It peeks at status every cycle until busy is low while data loaded is still high; that is the single cycle before the engine pops.
- It issues the third write on exactly that edge.

The case is judged twice. Transmit overrun must stay clear. All three bytes must return in order through a loopback of tx_line into rx_line.

// File: rtl/uart_dualbuf_pkg.sv
// Package: shared constants and types for the serial transceiver.
// Assumes a 4-bit byte address with 32-bit words at fixed offsets.
package uart_dualbuf_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_DATA = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_FILL = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 4'hC;

    // control word bit positions
    localparam int CB_RX_EN   = 0;
    localparam int CB_RX_FIFO = 1;
    localparam int CB_RX_RST  = 2;
    localparam int CB_TX_EN   = 16;
    localparam int CB_TX_FIFO = 17;
    localparam int CB_TX_RST  = 18;

    // status word bit positions
    localparam int SB_RX_EMPTY = 0;
    localparam int SB_RX_FULL  = 1;
    localparam int SB_RX_READY = 2;
    localparam int SB_RX_OVR   = 3;
    localparam int SB_RX_IRQ   = 4;
    localparam int SB_RX_FIFO  = 5;
    localparam int SB_RX_EN    = 6;
    localparam int SB_RX_RST   = 7;
    localparam int SB_TX_EMPTY = 16;
    localparam int SB_TX_FULL  = 17;
    localparam int SB_TX_BUSY  = 18;
    localparam int SB_TX_LOAD  = 19;
    localparam int SB_TX_OVR   = 20;
    localparam int SB_TX_IRQ   = 21;
    localparam int SB_TX_FIFO  = 22;
    localparam int SB_TX_EN    = 23;
    localparam int SB_TX_RST   = 24;

    localparam int FRAME_DATA_BITS = 8;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP
    } rx_state_t;

endpackage

// File: rtl/ub_buffer.sv
// Module: byte buffer that is either a ring FIFO of DEPTH entries or a
// single holding register, selected at run time by fifo_en.
// Assumes DEPTH is a power of two. A push and a pop in the same cycle
// are both honoured even when the buffer is full.
module ub_buffer #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fifo_en,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full,
    output logic             drop
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_pop;
    logic             do_push;

    // capacity depends on mode: DEPTH entries or one entry
    always_comb begin
        empty   = (count == '0);
        full    = fifo_en ? (count == CW'(DEPTH)) : (count != '0);
        do_pop  = pop && !empty && !clr;
        do_push = push && !clr && (!full || do_pop);
        drop    = push && !clr && !do_push;
        rdata   = mem[rd_ptr];
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // storage write, no reset needed on the data array
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/ub_tx_engine.sv
// Module: 8N1 serialiser. Takes one byte from its buffer when idle and
// enabled, then shifts start, eight data bits (LSB first) and stop, each
// held for `divisor` clock cycles. Assumes divisor >= 1.
module ub_tx_engine #(
    parameter int DIV_W = 16,
    localparam int FRAME_W = uart_dualbuf_pkg::FRAME_DATA_BITS + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             enable,
    input  logic [DIV_W-1:0] divisor,
    input  logic             have_data,
    input  logic [7:0]       byte_in,
    output logic             take,
    output logic             busy,
    output logic             line
);

    logic [FRAME_W-1:0] shreg;
    logic [3:0]         bitn;
    logic [DIV_W-1:0]   cnt;

    // start a frame only from idle with a byte waiting
    always_comb begin
        take = enable && !busy && have_data && !clr;
        line = busy ? shreg[0] : 1'b1;
    end

    // bit timing and shifting of the frame
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy  <= 1'b0;
            shreg <= '1;
            bitn  <= '0;
            cnt   <= '0;
        end else if (take) begin
            busy  <= 1'b1;
            shreg <= {1'b1, byte_in, 1'b0};
            bitn  <= '0;
            cnt   <= divisor - DIV_W'(1);
        end else if (busy) begin
            if (cnt == '0) begin
                if (bitn == 4'(FRAME_W - 1)) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= {1'b1, shreg[FRAME_W-1:1]};
                    bitn  <= bitn + 4'd1;
                    cnt   <= divisor - DIV_W'(1);
                end
            end else begin
                cnt <= cnt - DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/ub_rx_engine.sv
// Module: 8N1 deserialiser with a two-flop input synchroniser. Detects a
// falling edge, confirms the start bit half a bit later, then samples
// each data bit one divisor apart. A byte is presented for one cycle on
// valid if the stop bit reads high. Assumes divisor >= 4.
module ub_rx_engine #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             enable,
    input  logic [DIV_W-1:0] divisor,
    input  logic             line_async,
    output logic             valid,
    output logic [7:0]       byte_out
);
    import uart_dualbuf_pkg::*;

    rx_state_t        state;
    logic [1:0]       sync;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic             smp;

    assign smp = sync[1];

    // bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], line_async};
    end

    // frame recovery state machine
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state    <= RXS_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            byte_out <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                RXS_IDLE: begin
                    if (enable && !smp) begin
                        state <= RXS_START;
                        cnt   <= (divisor >> 1) - DIV_W'(1);
                    end
                end
                RXS_START: begin
                    if (cnt == '0) begin
                        if (!smp) begin
                            state <= RXS_DATA;
                            bitn  <= '0;
                            cnt   <= divisor - DIV_W'(1);
                        end else begin
                            state <= RXS_IDLE;
                        end
                    end else begin
                        cnt <= cnt - DIV_W'(1);
                    end
                end
                RXS_DATA: begin
                    if (cnt == '0) begin
                        byte_out <= {smp, byte_out[7:1]};
                        cnt      <= divisor - DIV_W'(1);
                        if (bitn == 3'd7) state <= RXS_STOP;
                        else              bitn  <= bitn + 3'd1;
                    end else begin
                        cnt <= cnt - DIV_W'(1);
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        valid <= smp;
                        state <= RXS_IDLE;
                    end else begin
                        cnt <= cnt - DIV_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_dualbuf.sv
// Module: memory-mapped 8N1 transceiver top. Decodes four word offsets,
// holds control and divisor registers, tracks sticky overrun flags and
// builds status, fill and interrupt outputs. Assumes one bus access per
// cycle; bus_rdata is combinational from bus_addr, and a read strobe at
// the data offset removes one received byte at the clock edge.
module uart_dualbuf #(
    parameter int          DEPTH     = 16,
    parameter int          DIV_W     = 16,
    parameter int          DIV_RESET = 16,
    parameter logic [31:0] SYSCLK_HZ = 32'd100_000_000,
    localparam int         CW        = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_line,
    output logic        tx_line,
    output logic        irq_rx,
    output logic        irq_tx
);
    import uart_dualbuf_pkg::*;

    logic ctl_rx_en, ctl_rx_fifo, ctl_rx_rst;
    logic ctl_tx_en, ctl_tx_fifo, ctl_tx_rst;
    logic [DIV_W-1:0] tx_div, rx_div;
    logic tx_ovr, rx_ovr;

    logic wr_data, wr_ctrl, wr_div, rd_data;
    logic tx_push, tx_take, tx_busy, tx_empty, tx_full, tx_drop;
    logic rx_valid, rx_empty, rx_full, rx_drop;
    logic [7:0] tx_head, rx_head, rx_byte;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [31:0] status_w, fill_w;

    // bus strobe decode
    always_comb begin
        wr_data = bus_sel && bus_we  && (bus_addr == OFS_DATA);
        wr_ctrl = bus_sel && bus_we  && (bus_addr == OFS_CTRL);
        wr_div  = bus_sel && bus_we  && (bus_addr == OFS_DIV);
        rd_data = bus_sel && !bus_we && (bus_addr == OFS_DATA);
        tx_push = wr_data && !ctl_tx_rst;
    end

    // control and divisor registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ctl_rx_en, ctl_rx_fifo, ctl_rx_rst} <= '0;
            {ctl_tx_en, ctl_tx_fifo, ctl_tx_rst} <= '0;
            tx_div <= DIV_W'(DIV_RESET);
            rx_div <= DIV_W'(DIV_RESET);
        end else begin
            if (wr_ctrl) begin
                ctl_rx_en   <= bus_wdata[CB_RX_EN];
                ctl_rx_fifo <= bus_wdata[CB_RX_FIFO];
                ctl_rx_rst  <= bus_wdata[CB_RX_RST];
                ctl_tx_en   <= bus_wdata[CB_TX_EN];
                ctl_tx_fifo <= bus_wdata[CB_TX_FIFO];
                ctl_tx_rst  <= bus_wdata[CB_TX_RST];
            end
            if (wr_div) begin
                tx_div <= bus_wdata[16 +: DIV_W];
                rx_div <= bus_wdata[0 +: DIV_W];
            end
        end
    end

    // sticky overrun flags, cleared by the direction reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ovr <= 1'b0;
            rx_ovr <= 1'b0;
        end else begin
            if (ctl_tx_rst)   tx_ovr <= 1'b0;
            else if (tx_drop) tx_ovr <= 1'b1;
            if (ctl_rx_rst)   rx_ovr <= 1'b0;
            else if (rx_drop) rx_ovr <= 1'b1;
        end
    end

    ub_buffer #(.DEPTH(DEPTH), .WIDTH(8)) u_tx_buf (
        .clk(clk), .rst_n(rst_n), .clr(ctl_tx_rst), .fifo_en(ctl_tx_fifo),
        .push(tx_push), .wdata(bus_wdata[7:0]), .pop(tx_take),
        .rdata(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full),
        .drop(tx_drop)
    );

    ub_tx_engine #(.DIV_W(DIV_W)) u_tx_eng (
        .clk(clk), .rst_n(rst_n), .clr(ctl_tx_rst), .enable(ctl_tx_en),
        .divisor(tx_div), .have_data(!tx_empty), .byte_in(tx_head),
        .take(tx_take), .busy(tx_busy), .line(tx_line)
    );

    ub_rx_engine #(.DIV_W(DIV_W)) u_rx_eng (
        .clk(clk), .rst_n(rst_n), .clr(ctl_rx_rst), .enable(ctl_rx_en),
        .divisor(rx_div), .line_async(rx_line), .valid(rx_valid),
        .byte_out(rx_byte)
    );

    ub_buffer #(.DEPTH(DEPTH), .WIDTH(8)) u_rx_buf (
        .clk(clk), .rst_n(rst_n), .clr(ctl_rx_rst), .fifo_en(ctl_rx_fifo),
        .push(rx_valid), .wdata(rx_byte), .pop(rd_data),
        .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full),
        .drop(rx_drop)
    );

    // interrupt levels per direction
    always_comb begin
        irq_rx = ctl_rx_en && (!rx_empty || rx_ovr);
        irq_tx = ctl_tx_en && (tx_empty || tx_ovr);
    end

    // status and fill word assembly
    always_comb begin
        status_w              = '0;
        status_w[SB_RX_EMPTY] = rx_empty;
        status_w[SB_RX_FULL]  = rx_full;
        status_w[SB_RX_READY] = !rx_empty;
        status_w[SB_RX_OVR]   = rx_ovr;
        status_w[SB_RX_IRQ]   = irq_rx;
        status_w[SB_RX_FIFO]  = ctl_rx_fifo;
        status_w[SB_RX_EN]    = ctl_rx_en;
        status_w[SB_RX_RST]   = ctl_rx_rst;
        status_w[SB_TX_EMPTY] = tx_empty;
        status_w[SB_TX_FULL]  = tx_full;
        status_w[SB_TX_BUSY]  = tx_busy;
        status_w[SB_TX_LOAD]  = !tx_empty;
        status_w[SB_TX_OVR]   = tx_ovr;
        status_w[SB_TX_IRQ]   = irq_tx;
        status_w[SB_TX_FIFO]  = ctl_tx_fifo;
        status_w[SB_TX_EN]    = ctl_tx_en;
        status_w[SB_TX_RST]   = ctl_tx_rst;
        fill_w                = '0;
        fill_w[0 +: CW]       = rx_cnt;
        fill_w[16 +: CW]      = tx_cnt;
    end

    // read data multiplexer
    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
            OFS_CTRL: bus_rdata = status_w;
            OFS_FILL: bus_rdata = fill_w;
            OFS_DIV:  bus_rdata = SYSCLK_HZ;
            default:  bus_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/uart_dualbuf_checker.sv
// Checker: temporal properties of the transceiver, bound to its top.
module uart_dualbuf_checker #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_busy,
    input logic          tx_line,
    input logic          tx_full,
    input logic          tx_ovr,
    input logic [CW-1:0] tx_cnt,
    input logic          ctl_tx_rst,
    input logic          rx_full,
    input logic          rx_ovr,
    input logic          rx_empty,
    input logic [CW-1:0] rx_cnt,
    input logic          ctl_rx_fifo,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [3:0]    bus_addr,
    input logic [31:0]   bus_rdata
);

    assert_start_bit_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !tx_line);

    assert_tx_ovr_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ovr) |-> $past(tx_full));

    assert_rx_ovr_only_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $past(rx_full));

    assert_single_mode_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rx_fifo && rx_cnt != '0) |=> (rx_cnt <= $past(rx_cnt)));

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 4'h0 && rx_empty) |-> (bus_rdata == 32'd0));

    assert_tx_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_tx_rst |=> (tx_cnt == '0 && !tx_ovr));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

endmodule

bind uart_dualbuf uart_dualbuf_checker #(.DEPTH(DEPTH)) u_checker (
    .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .tx_line(tx_line),
    .tx_full(tx_full), .tx_ovr(tx_ovr), .tx_cnt(tx_cnt),
    .ctl_tx_rst(ctl_tx_rst), .rx_full(rx_full), .rx_ovr(rx_ovr),
    .rx_empty(rx_empty), .rx_cnt(rx_cnt), .ctl_rx_fifo(ctl_rx_fifo),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/uart_dualbuf_bench.sv
`timescale 1ns/1ps
// Bench: loopback sweep of all byte values plus directed corner cases.
module uart_dualbuf_bench;

    localparam logic [31:0] SYSCLK = 32'd50_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        rx_line, tx_line, irq_rx, irq_tx;
    logic        loop_en = 1'b0, drv_rx = 1'b1;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;
    assign rx_line = loop_en ? tx_line : drv_rx;

    uart_dualbuf #(.DEPTH(16), .DIV_W(16), .DIV_RESET(16), .SYSCLK_HZ(SYSCLK)) u_uart_dualbuf (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_line(rx_line), .tx_line(tx_line), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr_now(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic rd_pop(output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'h0;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_ready(input string tag);
        logic [31:0] st;
        bit ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            peek(4'h4, st);
            if (st[2]) begin ok = 1'b1; break; end
        end
        if (!ok) chk(tag, 32'd0, 32'd1);
    endtask

    task automatic drive_rx(input logic [7:0] b, input int div);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            drv_rx = fr[i];
            repeat (div) @(negedge clk);
        end
        drv_rx = 1'b1;
    endtask

    task automatic capture_tx(input int div, output logic [7:0] b, output int lowlen);
        b = '0; lowlen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!tx_line) break;
        end
        while (!tx_line && lowlen < 100) begin
            lowlen++;
            @(negedge clk);
        end
        repeat (div / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            b[i] = tx_line;
            if (i < 7) repeat (div) @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] st, v;
        logic [7:0]  cb;
        int          ll;
        bit          found;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state, R1 offset decoding
        peek(4'h4, st); chk("R2 reset status", st, 32'h0001_0001);
        peek(4'h8, st); chk("R2 reset fill", st, 32'd0);
        chk("R2 reset irqs and line", {29'd0, irq_rx, irq_tx, tx_line}, 32'd1);
        peek(4'hC, st); chk("R1 divisor offset reads sysclk", st, SYSCLK);
        peek(4'h2, st); chk("R1 unmapped offset reads zero", st, 32'd0);

        // R7 configuration echo, R9 tx interrupt on empty
        wr(4'h4, 32'h0003_0003);
        wr(4'hC, 32'h0004_0004);
        peek(4'h4, st); chk("R7 R9 status after enable", st, 32'h00E1_0061);
        chk("R9 irq levels", {30'd0, irq_rx, irq_tx}, 32'd1);

        // R3 R4 loopback sweep of all byte values
        loop_en = 1'b1;
        for (int x = 0; x < 256; x++) begin
            wr(4'h0, 32'(x));
            wait_ready("R4 loopback ready timeout");
            rd_pop(v);
            chk("R3 R4 loopback byte", v, 32'(x));
        end

        // R5 R11 FIFO fill with transmit held off
        wr(4'h4, 32'h0002_0003);
        for (int i = 0; i < 16; i++) wr(4'h0, 32'((i * 17 + 3) & 8'hFF));
        peek(4'h8, st); chk("R10 tx fill count 16", st, 32'h0010_0000);
        peek(4'h4, st);
        chk("R5 tx full", 32'(st[17]), 32'd1);
        chk("R11 no send while disabled", 32'(st[18]), 32'd0);
        wr(4'h0, 32'hEE);
        peek(4'h4, st); chk("R5 tx overrun on 17th", 32'(st[20]), 32'd1);
        chk("R9 irq_tx gated by enable", 32'(irq_tx), 32'd0);
        wr(4'h4, 32'h0003_0003);
        repeat (16 * 40 + 80) @(negedge clk);
        peek(4'h8, st); chk("R10 rx fill count 16", st, 32'h0000_0010);
        peek(4'h4, st); chk("R6 rx fifo full", 32'(st[1]), 32'd1);
        chk("R9 irq_tx from overrun", 32'(irq_tx), 32'd1);
        for (int i = 0; i < 16; i++) begin
            rd_pop(v);
            chk("R5 R6 fifo order", v, 32'((i * 17 + 3) & 8'hFF));
        end

        // R8 transmit reset clears overrun and ignores writes
        wr(4'h4, 32'h0007_0003);
        wr(4'h0, 32'h5A);
        peek(4'h8, st); chk("R8 write ignored in reset", st, 32'd0);
        peek(4'h4, st); chk("R8 R7 tx in reset flag", {31'd0, st[24]}, 32'd1);
        chk("R8 tx overrun cleared", 32'(st[20]), 32'd0);
        chk("R8 line idle in reset", 32'(tx_line), 32'd1);
        wr(4'h4, 32'h0003_0003);

        // R3 R4 independent divisors
        loop_en = 1'b0;
        wr(4'hC, 32'h0008_0006);
        wr(4'h0, 32'h55);
        capture_tx(8, cb, ll);
        chk("R3 start bit length equals tx divisor", 32'(ll), 32'd8);
        chk("R3 captured byte", 32'(cb), 32'h55);
        repeat (20) @(negedge clk);
        drive_rx(8'hC3, 6);
        repeat (4) @(negedge clk);
        rd_pop(v); chk("R4 receive at rx divisor", v, 32'hC3);

        // R4 glitch rejection
        @(negedge clk); drv_rx = 1'b0;
        @(negedge clk); drv_rx = 1'b1;
        repeat (80) @(negedge clk);
        peek(4'h8, st); chk("R4 glitch gives no byte", st, 32'd0);

        // R6 single-register receive, overrun, empty read
        wr(4'h4, 32'h0003_0001);
        drive_rx(8'h11, 6);
        repeat (4) @(negedge clk);
        peek(4'h4, st); chk("R6 single mode ready and full", st & 32'hF, 32'h6);
        drive_rx(8'h22, 6);
        repeat (4) @(negedge clk);
        peek(4'h4, st); chk("R6 single mode overrun", 32'(st[3]), 32'd1);
        chk("R9 irq_rx", 32'(irq_rx), 32'd1);
        rd_pop(v); chk("R6 oldest byte kept", v, 32'h11);
        peek(4'h4, st); chk("R6 ready cleared", st & 32'h7, 32'h1);
        rd_pop(v); chk("R6 empty read zero", v, 32'd0);
        wr(4'h4, 32'h0003_0005);
        peek(4'h4, st); chk("R8 rx reset flags", st & 32'h8F, 32'h81);
        wr(4'h4, 32'h0003_0003);

        // R5 push in the same cycle the transmitter pops a full buffer
        wr(4'hC, 32'h0004_0004);
        loop_en = 1'b1;
        wr(4'h4, 32'h0001_0003);
        wr(4'h0, 32'h3C);
        repeat (3) @(negedge clk);
        wr(4'h0, 32'hA5);
        peek(4'h4, st); chk("R11 data loaded", 32'(st[19]), 32'd1);
        found = 1'b0;
        for (int i = 0; i < 200; i++) begin
            peek(4'h4, st);
            if (!st[18] && st[19]) begin
                wr_now(4'h0, 32'h96);
                found = 1'b1;
                break;
            end
        end
        chk("R5 pop cycle found", 32'(found), 32'd1);
        peek(4'h4, st); chk("R5 no overrun on push during pop", st & 32'h001C_0000, 32'h000C_0000);
        repeat (200) @(negedge clk);
        rd_pop(v); chk("R5 first byte", v, 32'h3C);
        rd_pop(v); chk("R5 second byte", v, 32'hA5);
        rd_pop(v); chk("R5 third byte", v, 32'h96);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule